// File: doc/BRIEF.md
# Nonvolatile Byte-Write Control Unit

This unit sits on a simple single-cycle register port and controls a byte-wide nonvolatile store. Software loads a target address through a low byte register and a high byte register, loads the byte to store through a data register, and then starts the operation from a control register. The nonvolatile cells are modelled by a small register file. A write takes a fixed number of clock cycles, which stands in for a programming time of several milliseconds. A read completes in one cycle.

A write starts only after a two-step handshake. Software first sets an arming bit. That bit clears itself after a short window. The write strobe must arrive while the arming bit is still set, or the strobe has no effect. The strobe bit stays high for the whole programming time, and hardware clears it when the byte has been committed. A ready condition holds for as long as no write is in progress. The interrupt line is that level ANDed with a mask bit. Software therefore keeps the mask set while it has bytes queued and clears the mask when the queue is empty.

Top module: `nvm_wr_unit`

## Requirements
- R1: After reset, every register reads 0x00, the interrupt output is low, and every byte of the store holds 0x00.
- R2: Register offsets on `busAddr` are 0 = control, 1 = data, 2 = address low byte, and 3 = address high byte. The high byte keeps only its low ADDR_W-8 bits, and the other bits read as 0. In the control register, bit 3 is the interrupt mask, bit 2 is the arming bit, bit 1 is the write strobe and bit 0 is the read strobe. Bits 7..4 and bit 0 always read as 0.
- R3: Writing 1 to control bit 2 while it is clear sets the arming bit. The arming bit then clears itself at the ARM_WIN-th rising edge after that write (4 by default), or earlier when it is used by a write start. Writing 0 to bit 2 has no effect, and writing 1 again while the bit is already set does not extend the window.
- R4: A control write with bit 1 set starts a write if the arming bit was already set before that write and no write is in progress. This is the case when the strobe write comes 1 to ARM_WIN cycles after the arming write. Starting a write sets bit 1 and clears the arming bit.
- R5: A write strobe is ignored, and bit 1 stays clear, in three cases: no arming write came before it, it came ARM_WIN+1 or more cycles after the arming write, or it was in the same control write that set the arming bit.
- R6: Bit 1 stays set for exactly WRITE_CYC cycles after the write starts. At the edge where hardware clears it, the data register is stored at the address that was latched.
- R7: The interrupt output is high in every cycle in which the mask is set and no write is in progress, for any length of time. It is low while a write is in progress, and it is low whenever the mask is clear.
- R8: While a write is in progress, bus writes to the address and data registers are ignored, so the write in progress stores its original byte at its original address.
- R9: A control write with bit 0 set while idle loads the byte at the current address into the data register on the next edge. While a write is in progress the read strobe has no effect.
- R10: The full address is the high register above the low byte. Locations that differ only in the high register are separate bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register offset |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Level ready interrupt: mask AND not busy |

## Verification
The store-and-recall path is exercised with two address and data patterns. The first pattern puts its strobe right after arming; the second puts it three cycles later. Readback at the same low byte with different high bytes separates real address composition from aliasing. The arming window is probed from both sides: a strobe on the last accepted cycle, one cycle later, with no arming at all, and in the same write as arming. This separates an exact window from an off-by-one window or from a missing check. The busy length is counted cycle by cycle. Register writes and a read strobe issued during the busy time show whether the latched operands are frozen. The interrupt is held for long idle stretches, with the mask set and then cleared, to tell a continuous level from a one-shot pulse.

// File: rtl/nvm_wr_pkg.sv
package nvm_wr_pkg;

  // register offsets on the bus
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_DATA = 2'd1;
  localparam logic [1:0] REG_ALO  = 2'd2;
  localparam logic [1:0] REG_AHI  = 2'd3;

  // control register bit positions
  localparam int BIT_IE  = 3;
  localparam int BIT_ARM = 2;
  localparam int BIT_WE  = 1;
  localparam int BIT_RE  = 0;

  // strobes from control to datapath
  typedef struct packed {
    logic ldAddrLo;
    logic ldAddrHi;
    logic ldData;
    logic doRead;
    logic doCommit;
  } nvmStrb_t;

endpackage

// File: rtl/nvm_wr_datapath.sv
module nvm_wr_datapath
  import nvm_wr_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvmStrb_t          strb,
  input  logic [7:0]        busWdata,
  input  logic [1:0]        busAddr,
  input  logic [7:0]        ctrlByte,
  output logic [7:0]        busRdata,
  output logic [ADDR_W-1:0] curAddr
);

  localparam int HI_W  = ADDR_W - 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]      addrLo;
  logic [HI_W-1:0] addrHi;
  logic [7:0]      dataReg;
  logic [7:0]      cellArr [DEPTH];
  logic [7:0]      hiByte;

  assign curAddr = {addrHi, addrLo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrLo  <= '0;
      addrHi  <= '0;
      dataReg <= '0;
      for (int i = 0; i < DEPTH; i++) cellArr[i] <= '0;
    end else begin
      if (strb.ldAddrLo) addrLo <= busWdata;
      if (strb.ldAddrHi) addrHi <= busWdata[HI_W-1:0];
      if (strb.doRead)      dataReg <= cellArr[curAddr];
      else if (strb.ldData) dataReg <= busWdata;
      if (strb.doCommit) cellArr[curAddr] <= dataReg;
    end
  end

  generate
    if (HI_W < 8) begin : g_hiPad
      assign hiByte = {{(8-HI_W){1'b0}}, addrHi};
    end else begin : g_hiFull
      assign hiByte = addrHi;
    end
  endgenerate

  always_comb begin
    unique case (busAddr)
      REG_CTRL: busRdata = ctrlByte;
      REG_DATA: busRdata = dataReg;
      REG_ALO:  busRdata = addrLo;
      default:  busRdata = hiByte;
    endcase
  end

endmodule

// File: rtl/nvm_wr_control.sv
module nvm_wr_control
  import nvm_wr_pkg::*;
#(
  parameter int ARM_WIN   = 4,
  parameter int WRITE_CYC = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic [3:0] ctrlBits,
  output logic [7:0] ctrlByte,
  output logic       irq,
  output nvmStrb_t   strb
);

  localparam int ARM_CW  = $clog2(ARM_WIN + 1);
  localparam int BUSY_CW = $clog2(WRITE_CYC + 1);

  logic               maskEn;
  logic               armed;
  logic               busy;
  logic [ARM_CW-1:0]  armCnt;
  logic [BUSY_CW-1:0] busyCnt;

  logic anyWr, ctrlWr, armReq, startReq, readReq, busyDone, armDone;

  assign anyWr    = busSel && busWr;
  assign ctrlWr   = anyWr && (busAddr == REG_CTRL);
  assign armReq   = ctrlWr && ctrlBits[BIT_ARM] && !armed;
  assign startReq = ctrlWr && ctrlBits[BIT_WE] && armed && !busy;
  assign readReq  = ctrlWr && ctrlBits[BIT_RE] && !busy && !startReq;
  assign busyDone = busy && (busyCnt == '0);
  assign armDone  = armed && (armCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskEn  <= 1'b0;
      armed   <= 1'b0;
      armCnt  <= '0;
      busy    <= 1'b0;
      busyCnt <= '0;
    end else begin
      if (ctrlWr) maskEn <= ctrlBits[BIT_IE];

      if (armed && (startReq || armDone)) begin
        armed <= 1'b0;
      end else if (armReq) begin
        armed  <= 1'b1;
        armCnt <= ARM_CW'(ARM_WIN - 1);
      end else if (armed) begin
        armCnt <= armCnt - 1'b1;
      end

      if (startReq) begin
        busy    <= 1'b1;
        busyCnt <= BUSY_CW'(WRITE_CYC - 1);
      end else if (busyDone) begin
        busy <= 1'b0;
      end else if (busy) begin
        busyCnt <= busyCnt - 1'b1;
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.ldAddrLo = anyWr && (busAddr == REG_ALO)  && !busy;
    strb.ldAddrHi = anyWr && (busAddr == REG_AHI)  && !busy;
    strb.ldData   = anyWr && (busAddr == REG_DATA) && !busy;
    strb.doRead   = readReq;
    strb.doCommit = busyDone;
  end

  assign ctrlByte = {4'b0000, maskEn, armed, busy, 1'b0};
  assign irq      = maskEn && !busy;

endmodule

// File: rtl/nvm_wr_unit.sv
module nvm_wr_unit
  import nvm_wr_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int ARM_WIN   = 4,
  parameter int WRITE_CYC = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       irq
);

  nvmStrb_t          strb;
  logic [7:0]        ctrlByte;
  logic [ADDR_W-1:0] curAddr;

  nvm_wr_control #(
    .ARM_WIN  (ARM_WIN),
    .WRITE_CYC(WRITE_CYC)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .ctrlBits(busWdata[3:0]),
    .ctrlByte(ctrlByte),
    .irq     (irq),
    .strb    (strb)
  );

  nvm_wr_datapath #(
    .ADDR_W(ADDR_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busWdata(busWdata),
    .busAddr (busAddr),
    .ctrlByte(ctrlByte),
    .busRdata(busRdata),
    .curAddr (curAddr)
  );

endmodule

// File: rtl/nvm_wr_unit_chk.sv
module nvm_wr_unit_chk #(
  parameter int ADDR_W    = 9,
  parameter int ARM_WIN   = 4,
  parameter int WRITE_CYC = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [1:0]        busAddr,
  input logic [7:0]        busRdata,
  input logic              irq,
  input logic [7:0]        ctrlByte,
  input logic [ADDR_W-1:0] curAddr
);

  logic mEn, arm, wip;
  int   armRun, busyRun;

  assign mEn = ctrlByte[3];
  assign arm = ctrlByte[2];
  assign wip = ctrlByte[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armRun  <= 0;
      busyRun <= 0;
    end else begin
      armRun  <= arm ? armRun + 1 : 0;
      busyRun <= wip ? busyRun + 1 : 0;
    end
  end

  // R2: unused control bits and the read strobe read back as zero
  assert_ctrl_zero_bits_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && busAddr == 2'd0) |-> (busRdata[7:4] == 4'h0 && busRdata[0] == 1'b0));

  // R3: the arming bit never stays up longer than the window
  assert_arm_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    armRun <= ARM_WIN);

  // R4: a write only begins while armed
  assert_start_armed_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wip) |-> $past(arm));

  // R6: busy time is exactly the programmed length
  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wip) |-> busyRun == WRITE_CYC);

  // R7: interrupt rises as soon as a write ends with the mask on
  assert_irq_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(wip) && mEn) |-> irq);

  // R7: mask off suppresses the interrupt
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    !mEn |-> !irq);

  // R8: the latched address is frozen during a write
  assert_addr_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wip && $past(wip)) |-> $stable(curAddr));

endmodule

bind nvm_wr_unit nvm_wr_unit_chk #(
  .ADDR_W   (ADDR_W),
  .ARM_WIN  (ARM_WIN),
  .WRITE_CYC(WRITE_CYC)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWr   (busWr),
  .busAddr (busAddr),
  .busRdata(busRdata),
  .irq     (irq),
  .ctrlByte(ctrlByte),
  .curAddr (curAddr)
);

// File: tb/nvm_wr_unit_tb.sv
module nvm_wr_unit_tb_top;

  localparam int ADDR_W    = 9;
  localparam int ARM_WIN   = 4;
  localparam int WRITE_CYC = 20;

  localparam logic [1:0] K_WR = 2'd0, K_CHK = 2'd1, K_IDLE = 2'd2;
  localparam int NVEC = 33;

  // {kind, reg, data-or-expected, requirement number}
  localparam logic [15:0] VEC [NVEC] = '{
    {K_WR,  2'd2, 8'h15, 4'd0},
    {K_WR,  2'd3, 8'h01, 4'd0},
    {K_WR,  2'd1, 8'hA5, 4'd0},
    {K_CHK, 2'd2, 8'h15, 4'd2},   // R2
    {K_CHK, 2'd3, 8'h01, 4'd2},
    {K_CHK, 2'd1, 8'hA5, 4'd2},
    {K_WR,  2'd3, 8'hFF, 4'd0},
    {K_CHK, 2'd3, 8'h01, 4'd2},   // R2 high byte width
    {K_WR,  2'd0, 8'h04, 4'd0},
    {K_WR,  2'd0, 8'h02, 4'd0},
    {K_CHK, 2'd0, 8'h02, 4'd4},   // R4 strobe one cycle after arming
    {K_IDLE,2'd0, 8'd25, 4'd0},
    {K_CHK, 2'd0, 8'h00, 4'd6},   // R6
    {K_WR,  2'd1, 8'h00, 4'd0},
    {K_CHK, 2'd1, 8'h00, 4'd2},
    {K_WR,  2'd0, 8'h01, 4'd0},
    {K_CHK, 2'd1, 8'hA5, 4'd9},   // R9 recall
    {K_CHK, 2'd0, 8'h00, 4'd2},
    {K_WR,  2'd3, 8'h00, 4'd0},
    {K_WR,  2'd0, 8'h01, 4'd0},
    {K_CHK, 2'd1, 8'h00, 4'd10},  // R10 0x015 separate from 0x115
    {K_WR,  2'd2, 8'hFF, 4'd0},
    {K_WR,  2'd3, 8'h00, 4'd0},
    {K_WR,  2'd1, 8'h3C, 4'd0},
    {K_WR,  2'd0, 8'h04, 4'd0},
    {K_IDLE,2'd0, 8'd2,  4'd0},
    {K_WR,  2'd0, 8'h02, 4'd0},   // R4 strobe three cycles after arming
    {K_IDLE,2'd0, 8'd25, 4'd0},
    {K_WR,  2'd1, 8'h00, 4'd0},
    {K_WR,  2'd0, 8'h01, 4'd0},
    {K_CHK, 2'd1, 8'h3C, 4'd4},   // R4 byte stored
    {K_WR,  2'd3, 8'h01, 4'd0},
    {K_WR,  2'd0, 8'h01, 4'd0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irq;

  int  nChk = 0, nFail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  nvm_wr_unit #(
    .ADDR_W(ADDR_W), .ARM_WIN(ARM_WIN), .WRITE_CYC(WRITE_CYC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  task automatic check(input int got, input int exp, input string tag);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    #1 busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #2 v = busRdata;
    busSel = 1'b0;
  endtask

  task automatic rdChk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    peek(a, v);
    check(int'(v), int'(exp), tag);
  endtask

  task automatic irqChk(input logic exp, input string tag);
    @(negedge clk);
    #2 check(int'(irq), int'(exp), tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts consecutive cycles a control bit reads high
  task automatic runLen(input int bitPos, output int n);
    logic [7:0] v;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      peek(2'd0, v);
      if (v[bitPos]) n++;
      else break;
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rdChk(2'd0, 8'h00, "R1 ctrl");
    rdChk(2'd1, 8'h00, "R1 data");
    rdChk(2'd2, 8'h00, "R1 addrLo");
    rdChk(2'd3, 8'h00, "R1 addrHi");
    irqChk(1'b0, "R1 irq");

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] e;
      e = VEC[i];
      case (e[15:14])
        K_WR:   wr(e[13:12], e[11:4]);
        K_CHK:  rdChk(e[13:12], e[11:4], $sformatf("R%0d vector %0d", e[3:0], i));
        default: idle(int'(e[11:4]));
      endcase
    end
    // R1: store byte 0x1FF untouched since reset
    rdChk(2'd1, 8'h00, "R1 store cleared");

    // R3 window length and no extension on re-arm
    wr(2'd0, 8'h04);
    runLen(2, n);
    check(n, ARM_WIN, "R3 arm window");
    wr(2'd0, 8'h04);
    wr(2'd0, 8'h04);
    runLen(2, n);
    check(n, ARM_WIN - 1, "R3 re-arm no extend");
    wr(2'd0, 8'h04);
    wr(2'd0, 8'h00);
    rdChk(2'd0, 8'h04, "R3 zero write no effect");
    idle(6);

    // R5 strobe without arming
    wr(2'd0, 8'h02);
    rdChk(2'd0, 8'h00, "R5 no arm");
    // R5 arm and strobe in one write
    wr(2'd0, 8'h06);
    rdChk(2'd0, 8'h04, "R5 same write");
    idle(6);
    // R4 last accepted cycle, R5 first rejected cycle
    wr(2'd0, 8'h04);
    idle(3);
    wr(2'd0, 8'h02);
    rdChk(2'd0, 8'h02, "R4 window edge");
    idle(25);
    wr(2'd0, 8'h04);
    idle(4);
    wr(2'd0, 8'h02);
    rdChk(2'd0, 8'h00, "R5 late strobe");

    // R6 busy length
    wr(2'd0, 8'h04);
    wr(2'd0, 8'h02);
    runLen(1, n);
    check(n, WRITE_CYC, "R6 busy length");

    // R7 continuous level, masked while busy and when mask clear
    wr(2'd0, 8'h08);
    irqChk(1'b1, "R7 irq on");
    idle(40);
    irqChk(1'b1, "R7 irq held");
    wr(2'd0, 8'h0C);
    wr(2'd0, 8'h0A);
    irqChk(1'b0, "R7 irq busy");
    idle(25);
    irqChk(1'b1, "R7 irq after write");
    wr(2'd0, 8'h00);
    irqChk(1'b0, "R7 irq masked");
    idle(30);
    irqChk(1'b0, "R7 irq masked held");

    // R8 / R9 activity during busy
    wr(2'd2, 8'h20);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'h77);
    wr(2'd0, 8'h04);
    wr(2'd0, 8'h02);
    wr(2'd2, 8'h33);
    wr(2'd1, 8'h11);
    wr(2'd0, 8'h03);
    rdChk(2'd2, 8'h20, "R8 addr frozen");
    rdChk(2'd1, 8'h77, "R9 read ignored busy");
    idle(25);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);
    rdChk(2'd1, 8'h77, "R8 original byte stored");
    wr(2'd2, 8'h33);
    wr(2'd0, 8'h01);
    rdChk(2'd1, 8'h00, "R8 ignored address untouched");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule